// File: doc/BRIEF.md
# Compressed Byte/Halfword and Unary-Op Expander

This block turns one 16-bit compressed instruction into the equivalent 32-bit base instruction word for a 64-bit core. It covers two groups of the code-size extension. The first is the byte and halfword load/store group in quadrant 0. The second is the multiply and single-operand extend/invert group in quadrant 1. The decoder in front of the integer pipeline places it in the path of each 16-bit parcel, and the wide word it produces is handed on to the normal 32-bit decoder.

Any 16-bit pattern outside these two groups is reported as illegal, with an all-zero output word, so that another expander (or the trap logic) can pick it up. The valid bit travels with the word. A build-time parameter selects either a purely combinational path or one output register stage, which adds one cycle of latency.

Top module: `cbh_expand`

## Requirements
- R1: Quadrant 0 (bits 1:0 = 00), bits 15:13 = 100, bits 12:10 = 000 expands to LBU, and bits 12:10 = 010 expands to SB. The byte offset is {bit5, bit6}, so bit 5 gives offset bit 1 and bit 6 gives offset bit 0.
- R2: In the same group, bits 12:10 = 001 expands to a halfword load with offset {bit5, 0}. Bit 6 = 0 gives LHU (funct3 101) and bit 6 = 1 gives LH (funct3 001).
- R3: Bits 12:10 = 011 expands to SH with offset {bit5, 0}. For SB and SH, the store data register comes from bits 4:2, the immediate sits in bits 11:7 of the output word, and bits 31:25 are zero.
- R4: A 3-bit register field r names register 8 + r. In the memory group, bits 9:7 give the base register and bits 4:2 give the data register. In the arithmetic group, bits 9:7 give the destination register and bits 4:2 give the second source register.
- R5: Quadrant 1 with bits 15:10 = 100111 and bits 6:5 = 10 expands to MUL rd, rd, rs2 (funct7 0000001, opcode 0110011).
- R6: With bits 6:5 = 11, bits 4:2 select a unary operation on rd. The encodings are: 0 = ANDI rd,rd,0xFF; 1 = SEXT.B (imm 0x604, funct3 001, opcode 0010011); 2 = ZEXT.H (funct7 0000100, rs2 0, funct3 100, opcode 0111011); 3 = SEXT.H (imm 0x605); 4 = ADD.UW rd,rd,x0 (funct7 0000100, funct3 000, opcode 0111011); 5 = XORI rd,rd,-1.
- R7: Unary selector values 6 and 7 set out_illegal and give out_instr = 0.
- R8: Memory-group subcodes 100 to 111 in bits 12:10 set out_illegal and give out_instr = 0.
- R9: Every other 16-bit pattern sets out_illegal and gives out_instr = 0. This includes the all-zero word, bits 6:5 = 00 or 01 in the arithmetic group, and bits 1:0 = 11.
- R10: out_valid follows in_valid. With OUT_REG = 0 the path is combinational. With OUT_REG = 1 all outputs appear one clock later, and reset clears out_valid, out_instr and out_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input parcel is valid |
| in_instr | input | 16 | Compressed instruction parcel |
| out_valid | output | 1 | Expanded word is valid |
| out_instr | output | 32 | Expanded 32-bit instruction, zero when illegal |
| out_illegal | output | 1 | Parcel is not an encoding this block expands |

## Verification
In the registered build, the stage presents the expansion of one parcel in the same cycle that it accepts the next parcel. A legal and an illegal result can therefore meet at the same clock edge, in either order. The bench provokes this by streaming back-to-back parcels with no gaps: every memory and arithmetic encoding, then random words, with in_valid toggled at random. It judges each registered output against the reference expansion of the parcel driven one cycle earlier, while the combinational build is checked against the current parcel.

// File: rtl/cbh_expand.sv
module cbh_expand #(
  parameter bit OUT_REG = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [15:0] in_instr,
  output logic        out_valid,
  output logic [31:0] out_instr,
  output logic        out_illegal
);
  localparam logic [6:0] OP_LOAD  = 7'b0000011;
  localparam logic [6:0] OP_STORE = 7'b0100011;
  localparam logic [6:0] OP_IMM   = 7'b0010011;
  localparam logic [6:0] OP_REG   = 7'b0110011;
  localparam logic [6:0] OP_REGW  = 7'b0111011;

  function automatic logic [31:0] itype(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] op);
    return {f7, rs2, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] stype(input logic [1:0] off, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3);
    return {7'd0, rs2, rs1, f3, 3'b000, off, OP_STORE};
  endfunction

  wire [4:0] reg_hi  = {2'b01, in_instr[9:7]};
  wire [4:0] reg_lo  = {2'b01, in_instr[4:2]};
  wire [2:0] sub     = in_instr[12:10];
  wire [1:0] boff    = {in_instr[5], in_instr[6]};
  wire [1:0] hoff    = {in_instr[5], 1'b0};
  wire       mem_grp = (in_instr[1:0] == 2'b00) && (in_instr[15:13] == 3'b100);
  wire       alu_grp = (in_instr[1:0] == 2'b01) && (in_instr[15:10] == 6'b100111);

  logic [31:0] word;
  logic        bad;

  always_comb begin
    word = '0;
    bad  = 1'b0;
    if (mem_grp) begin
      case (sub)
        3'b000:  word = itype({10'd0, boff}, reg_hi, 3'b100, reg_lo, OP_LOAD);
        3'b001:  word = itype({10'd0, hoff}, reg_hi, in_instr[6] ? 3'b001 : 3'b101,
                              reg_lo, OP_LOAD);
        3'b010:  word = stype(boff, reg_lo, reg_hi, 3'b000);
        3'b011:  word = stype(hoff, reg_lo, reg_hi, 3'b001);
        default: bad = 1'b1;
      endcase
    end else if (alu_grp && in_instr[6:5] == 2'b10) begin
      word = rtype(7'b0000001, reg_lo, reg_hi, 3'b000, reg_hi, OP_REG);
    end else if (alu_grp && in_instr[6:5] == 2'b11) begin
      case (in_instr[4:2])
        3'd0:    word = itype(12'h0FF, reg_hi, 3'b111, reg_hi, OP_IMM);
        3'd1:    word = itype(12'h604, reg_hi, 3'b001, reg_hi, OP_IMM);
        3'd2:    word = rtype(7'b0000100, 5'd0, reg_hi, 3'b100, reg_hi, OP_REGW);
        3'd3:    word = itype(12'h605, reg_hi, 3'b001, reg_hi, OP_IMM);
        3'd4:    word = rtype(7'b0000100, 5'd0, reg_hi, 3'b000, reg_hi, OP_REGW);
        3'd5:    word = itype(12'hFFF, reg_hi, 3'b100, reg_hi, OP_IMM);
        default: bad = 1'b1;
      endcase
    end else begin
      bad = 1'b1;
    end
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid   <= 1'b0;
          out_instr   <= '0;
          out_illegal <= 1'b0;
        end else begin
          out_valid   <= in_valid;
          out_instr   <= word;
          out_illegal <= bad;
        end
      end
    end else begin : g_comb
      assign out_valid   = in_valid;
      assign out_instr   = word;
      assign out_illegal = bad;
    end
  endgenerate
endmodule

// File: rtl/cbh_expand_chk.sv
module cbh_expand_chk #(
  parameter bit LAT = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_instr,
  input logic        out_valid,
  input logic [31:0] out_instr,
  input logic        out_illegal
);
  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  wire unary_hole = (in_instr[15:10] == 6'b100111) && (in_instr[6:5] == 2'b11) &&
                    (in_instr[4:3] == 2'b11) && (in_instr[1:0] == 2'b01);

  // R9
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_instr == 32'd0));

  // R4
  prime_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_instr[19:18] == 2'b01));

  // R9
  wide_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_instr[1:0] == 2'b11));

  generate
    if (LAT) begin : g_lat
      // R10
      valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (out_valid == $past(in_valid)));
      // R7
      unary_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started && $past(unary_hole)) |-> out_illegal);
    end else begin : g_nolat
      // R10
      valid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == in_valid);
      // R7
      unary_hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unary_hole |-> out_illegal);
    end
  endgenerate
endmodule

bind cbh_expand cbh_expand_chk #(.LAT(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
  .out_valid(out_valid), .out_instr(out_instr), .out_illegal(out_illegal)
);

// File: tb/cbh_expand_tb.sv
`timescale 1ns/1ps
module cbh_expand_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_instr = '0;
  logic        r_valid, c_valid, r_ill, c_ill;
  logic [31:0] r_instr, c_instr;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  cbh_expand #(.OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(r_valid), .out_instr(r_instr), .out_illegal(r_ill));

  cbh_expand #(.OUT_REG(1'b0)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .out_valid(c_valid), .out_instr(c_instr), .out_illegal(c_ill));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (parcel %h)", tag, act, exp, in_instr);
    end
  endtask

  function automatic void ref_expand(input logic [15:0] c, output logic [31:0] w,
                                     output logic ill, output string tag);
    logic [4:0] a, b;
    a = 5'd8 + {2'b00, c[9:7]};
    b = 5'd8 + {2'b00, c[4:2]};
    ill = 1'b0;
    casez (c)
      16'b100_000_???_??_???_00: begin tag = "R1";
        w = {10'd0, c[5], c[6], a, 3'b100, b, 7'b0000011}; end
      16'b100_001_???_0?_???_00: begin tag = "R2";
        w = {10'd0, c[5], 1'b0, a, 3'b101, b, 7'b0000011}; end
      16'b100_001_???_1?_???_00: begin tag = "R2";
        w = {10'd0, c[5], 1'b0, a, 3'b001, b, 7'b0000011}; end
      16'b100_010_???_??_???_00: begin tag = "R1";
        w = {7'd0, b, a, 3'b000, 3'b000, c[5], c[6], 7'b0100011}; end
      16'b100_011_???_??_???_00: begin tag = "R3";
        w = {7'd0, b, a, 3'b001, 3'b000, c[5], 1'b0, 7'b0100011}; end
      16'b100_1??_???_??_???_00: begin tag = "R8"; w = '0; ill = 1'b1; end
      16'b100_111_???_10_???_01: begin tag = "R5";
        w = {7'b0000001, b, a, 3'b000, a, 7'b0110011}; end
      16'b100_111_???_11_000_01: begin tag = "R6"; w = {12'h0FF, a, 3'b111, a, 7'b0010011}; end
      16'b100_111_???_11_001_01: begin tag = "R6"; w = {12'h604, a, 3'b001, a, 7'b0010011}; end
      16'b100_111_???_11_010_01: begin tag = "R6"; w = {12'h080, a, 3'b100, a, 7'b0111011}; end
      16'b100_111_???_11_011_01: begin tag = "R6"; w = {12'h605, a, 3'b001, a, 7'b0010011}; end
      16'b100_111_???_11_100_01: begin tag = "R6"; w = {12'h080, a, 3'b000, a, 7'b0111011}; end
      16'b100_111_???_11_101_01: begin tag = "R6"; w = {12'hFFF, a, 3'b100, a, 7'b0010011}; end
      16'b100_111_???_11_11?_01: begin tag = "R7"; w = '0; ill = 1'b1; end
      default:                   begin tag = "R9"; w = '0; ill = 1'b1; end
    endcase
  endfunction

  logic [31:0] prev_w;
  logic        prev_ill, prev_v;
  string       prev_tag;
  bit          have_prev = 1'b0;

  task automatic apply(input logic [15:0] c, input logic v);
    logic [31:0] w;
    logic        ill;
    string       tag;
    @(negedge clk);
    if (have_prev) begin
      check("R10 reg valid", {31'd0, r_valid}, {31'd0, prev_v});
      check({prev_tag, " reg word"}, r_instr, prev_w);
      check({prev_tag, " reg illegal"}, {31'd0, r_ill}, {31'd0, prev_ill});
    end
    in_instr = c;
    in_valid = v;
    #1;
    ref_expand(c, w, ill, tag);
    check("R10 comb valid", {31'd0, c_valid}, {31'd0, v});
    check({tag, " comb word"}, c_instr, w);
    check({tag, " comb illegal"}, {31'd0, c_ill}, {31'd0, ill});
    prev_w = w; prev_ill = ill; prev_v = v; prev_tag = tag; have_prev = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10 reset state of the registered build
    check("R10 reset valid", {31'd0, r_valid}, 32'd0);
    check("R10 reset word", r_instr, 32'd0);
    check("R10 reset illegal", {31'd0, r_ill}, 32'd0);
    rst_n = 1'b1;

    // R9 all-zero and all-one parcels
    apply(16'h0000, 1'b1);
    apply(16'hFFFF, 1'b1);

    // R4 register mapping, directed: LBU base x15, dest x8
    apply({3'b100, 3'b000, 3'b111, 2'b00, 3'b000, 2'b00}, 1'b1);
    check("R4 base reg", {27'd0, c_instr[19:15]}, 32'd15);
    check("R4 dest reg", {27'd0, c_instr[11:7]}, 32'd8);
    // R1 crossed offset: bit6=1, bit5=0 gives offset 1
    apply({3'b100, 3'b000, 3'b000, 2'b10, 3'b000, 2'b00}, 1'b1);
    check("R1 offset one", {20'd0, c_instr[31:20]}, 32'd1);

    // Exhaustive memory group (R1, R2, R3, R8)
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 8; a++)
        for (int m = 0; m < 4; m++)
          for (int b = 0; b < 8; b++)
            apply({3'b100, 3'(s), 3'(a), 2'(m), 3'(b), 2'b00}, 1'b1);

    // Exhaustive arithmetic group (R5, R6, R7, R9)
    for (int a = 0; a < 8; a++)
      for (int f = 0; f < 4; f++)
        for (int b = 0; b < 8; b++)
          apply({3'b100, 3'b111, 3'(a), 2'(f), 3'(b), 2'b01}, 1'b1);

    // Random parcels with random valid, mixing legal and illegal back to back
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      if (i % 3 == 0) r[15:13] = 3'b100;
      if (i % 6 == 0) r[12:10] = 3'b111;
      apply(r, 1'($urandom));
    end
    apply(16'h0000, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule